// File: doc/BRIEF.md
# Shared-Port RAM FIFO

This is a single-clock first-in first-out buffer whose storage is one RAM array. A write pointer always names the next free slot and a read pointer always names the oldest stored entry, so an accepted write or read finishes in the cycle it is requested. Occupancy is tracked in a counter, which drives the full and empty flags.

The parameter `SHARED_PORT` chooses how the array is addressed. With `SHARED_PORT = 1` the array has one address port. Read enable steers a 2:1 address multiplexer: high selects the read pointer, low selects the write pointer. The raw output therefore follows the write-pointer slot whenever no read is requested. It carries meaningful data only while read enable is high. With `SHARED_PORT = 0` the read pointer has its own read port, and the output always shows the slot at the read pointer.

The parameter `OUT_HOLD = 1` adds an output register that loads on every accepted read. It keeps the last value read steady while no read happens.

Top module: `sp_fifo`

## Requirements
- R1: An accepted write stores the data at the write-pointer slot. The write pointer then advances by one, wrapping modulo `DEPTH`, so a later read returns that data.
- R2: With `SHARED_PORT = 1` and `OUT_HOLD = 0`, the data output shows the stored contents at the read pointer while read enable is 1. It shows the contents at the write pointer while read enable is 0.
- R3: With `SHARED_PORT = 1`, a write requested in the same cycle as a read is not accepted. With `SHARED_PORT = 0`, both are accepted when the FIFO is neither empty nor full.
- R4: Full is 1 once `DEPTH` entries are stored. A write requested while full changes no stored data and does not move the write pointer.
- R5: With `SHARED_PORT = 1` and `OUT_HOLD = 0`, once the last free slot is written and read enable is 0, the data output shows the first-written entry, because the write pointer has wrapped to it.
- R6: Reads return entries in write order. A read requested while empty is ignored, and the read pointer does not move.
- R7: With `SHARED_PORT = 0` and `OUT_HOLD = 0`, the data output always shows the contents at the read pointer, whatever the value of read enable.
- R8: With `OUT_HOLD = 1`, the data output loads the value read on each accepted read. It holds that value unchanged in every other cycle.
- R9: Empty is 1 exactly when the occupancy is 0, and full is 1 exactly when the occupancy is `DEPTH`. The two are never 1 together.
- R10: Synchronous reset clears both pointers and the occupancy, sets empty to 1 and full to 0, and clears the output hold register to 0. It leaves stored data in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Write request |
| wrData | input | DATA_W | Data to write |
| rdEn | input | 1 | Read request; in shared-port mode it also selects the address |
| dataOut | output | DATA_W | Raw memory output, or the hold register when `OUT_HOLD = 1` |
| full | output | 1 | Occupancy equals `DEPTH` |
| empty | output | 1 | Occupancy is zero |

## Verification
The bench builds three copies with `DEPTH = 4` and `DATA_W = 8`, all driven by the same stimulus. The copies are shared-port without hold, separate read port without hold, and shared-port with hold. The small depth brings the full condition, pointer wrap and repeated writes while full within a few cycles. Running the copies side by side shows that a simultaneous read and write is refused in shared-port mode and accepted with a separate read port. The hold copy shows the output staying steady between reads, while the raw output tracks whichever address the mux selects.

// File: rtl/sp_fifo_pkg.sv
package sp_fifo_pkg;

  // Strobes from the control path to the datapath
  typedef struct packed {
    logic wrAcc;  // write accepted this cycle
    logic rdAcc;  // read accepted this cycle
    logic selRd;  // address mux select: 1 = read pointer
  } fifoStrobe_t;

endpackage

// File: rtl/sp_fifo_ctrl.sv
module sp_fifo_ctrl
  import sp_fifo_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter bit SHARED_PORT = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wrEn,
  input  logic                     rdEn,
  output fifoStrobe_t              strobe,
  output logic [$clog2(DEPTH)-1:0] wrAddr,
  output logic [$clog2(DEPTH)-1:0] rdAddr,
  output logic                     full,
  output logic                     empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_SLOT = AW'(DEPTH - 1);

  logic [CW-1:0] occupancy;
  logic          portFree;

  function automatic logic [AW-1:0] bumpPtr(input logic [AW-1:0] p);
    return (p == LAST_SLOT) ? '0 : p + 1'b1;
  endfunction

  // A shared port is taken by a read whenever read enable is high
  generate
    if (SHARED_PORT) begin : g_shared
      assign portFree = !rdEn;
    end else begin : g_dual
      assign portFree = 1'b1;
    end
  endgenerate

  assign full         = (occupancy == FULL_CNT);
  assign empty        = (occupancy == '0);
  assign strobe.wrAcc = wrEn && !full && portFree;
  assign strobe.rdAcc = rdEn && !empty;
  assign strobe.selRd = rdEn;

  always_ff @(posedge clk) begin
    if (rst) begin
      wrAddr    <= '0;
      rdAddr    <= '0;
      occupancy <= '0;
    end else begin
      if (strobe.wrAcc) wrAddr <= bumpPtr(wrAddr);
      if (strobe.rdAcc) rdAddr <= bumpPtr(rdAddr);
      case ({strobe.wrAcc, strobe.rdAcc})
        2'b10:   occupancy <= occupancy + 1'b1;
        2'b01:   occupancy <= occupancy - 1'b1;
        default: occupancy <= occupancy;
      endcase
    end
  end

  // R4: a full FIFO never moves its write pointer
  a_r4_full_freezes_wrptr : assert property (@(posedge clk) disable iff (rst)
    full |=> (wrAddr == $past(wrAddr)));

  // R6: an empty FIFO never moves its read pointer
  a_r6_empty_freezes_rdptr : assert property (@(posedge clk) disable iff (rst)
    empty |=> (rdAddr == $past(rdAddr)));

  // R9: flags are mutually exclusive
  a_r9_flags_exclusive : assert property (@(posedge clk) disable iff (rst)
    !(full && empty));

  // R1: an accepted write moves the write pointer
  a_r1_write_advances : assert property (@(posedge clk) disable iff (rst)
    strobe.wrAcc |=> (wrAddr != $past(wrAddr)));

  generate
    if (SHARED_PORT) begin : g_shared_chk
      // R3: a read and a write in the same cycle leave the write pointer alone
      a_r3_shared_write_blocked : assert property (@(posedge clk) disable iff (rst)
        (wrEn && rdEn) |=> (wrAddr == $past(wrAddr)));
    end
  endgenerate
endmodule

// File: rtl/sp_fifo_dpath.sv
module sp_fifo_dpath
  import sp_fifo_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DEPTH       = 16,
  parameter bit SHARED_PORT = 1'b1,
  parameter bit OUT_HOLD    = 1'b0
) (
  input  logic                     clk,
  input  logic                     rst,
  input  fifoStrobe_t              strobe,
  input  logic [$clog2(DEPTH)-1:0] wrAddr,
  input  logic [$clog2(DEPTH)-1:0] rdAddr,
  input  logic [DATA_W-1:0]        wrData,
  output logic [DATA_W-1:0]        dataOut
);
  localparam int AW = $clog2(DEPTH);

  logic [DATA_W-1:0] store [DEPTH];
  logic [AW-1:0]     portAddr;
  logic [DATA_W-1:0] rawOut;

  generate
    if (SHARED_PORT) begin : g_one_port
      // One address for both reading and writing
      assign portAddr = strobe.selRd ? rdAddr : wrAddr;
      always_ff @(posedge clk) begin
        if (strobe.wrAcc) store[portAddr] <= wrData;
      end
      // R3: a write only reaches the array when the port is not given to a read
      a_r3_port_not_shared : assert property (@(posedge clk) disable iff (rst)
        strobe.wrAcc |-> !strobe.selRd);
    end else begin : g_two_port
      assign portAddr = rdAddr;
      always_ff @(posedge clk) begin
        if (strobe.wrAcc) store[wrAddr] <= wrData;
      end
    end
  endgenerate

  assign rawOut = store[portAddr];

  generate
    if (OUT_HOLD) begin : g_hold
      logic [DATA_W-1:0] holdQ;
      always_ff @(posedge clk) begin
        if (rst)               holdQ <= '0;
        else if (strobe.rdAcc) holdQ <= rawOut;
      end
      assign dataOut = holdQ;
      // R8: the held output moves only on an accepted read
      a_r8_hold_steady : assert property (@(posedge clk) disable iff (rst)
        !strobe.rdAcc |=> $stable(dataOut));
    end else begin : g_raw
      assign dataOut = rawOut;
    end
  endgenerate
endmodule

// File: rtl/sp_fifo.sv
module sp_fifo
  import sp_fifo_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DEPTH       = 16,
  parameter bit SHARED_PORT = 1'b1,
  parameter bit OUT_HOLD    = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  output logic [DATA_W-1:0] dataOut,
  output logic              full,
  output logic              empty
);
  localparam int AW = $clog2(DEPTH);

  fifoStrobe_t   strobe;
  logic [AW-1:0] wrAddr;
  logic [AW-1:0] rdAddr;

  sp_fifo_ctrl #(
    .DEPTH(DEPTH), .SHARED_PORT(SHARED_PORT)
  ) ctrl_i (
    .clk(clk), .rst(rst), .wrEn(wrEn), .rdEn(rdEn), .strobe(strobe),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .full(full), .empty(empty)
  );

  sp_fifo_dpath #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .SHARED_PORT(SHARED_PORT), .OUT_HOLD(OUT_HOLD)
  ) dpath_i (
    .clk(clk), .rst(rst), .strobe(strobe), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .wrData(wrData), .dataOut(dataOut)
  );
endmodule

// File: tb/sp_fifo_tb_top.sv
module sp_fifo_tb_top;
  localparam int D  = 4;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic we = 1'b0;
  logic re = 1'b0;
  logic [DW-1:0] wd = '0;

  logic [DW-1:0] dout0, dout1, dout2;
  logic full0, full1, full2, empty0, empty1, empty2;

  int nChk = 0;
  int nBad = 0;

  // Reference model state, index 0 shared/raw, 1 dual/raw, 2 shared/hold
  int mMem [3][D];
  bit mVal [3][D];
  int mWp [3];
  int mRp [3];
  int mCnt [3];
  int mHold [3];

  always #10 clk = ~clk;

  sp_fifo #(.DATA_W(DW), .DEPTH(D), .SHARED_PORT(1'b1), .OUT_HOLD(1'b0)) dut_i (
    .clk(clk), .rst(rst), .wrEn(we), .wrData(wd), .rdEn(re),
    .dataOut(dout0), .full(full0), .empty(empty0));
  sp_fifo #(.DATA_W(DW), .DEPTH(D), .SHARED_PORT(1'b0), .OUT_HOLD(1'b0)) dutDual_i (
    .clk(clk), .rst(rst), .wrEn(we), .wrData(wd), .rdEn(re),
    .dataOut(dout1), .full(full1), .empty(empty1));
  sp_fifo #(.DATA_W(DW), .DEPTH(D), .SHARED_PORT(1'b1), .OUT_HOLD(1'b1)) dutHold_i (
    .clk(clk), .rst(rst), .wrEn(we), .wrData(wd), .rdEn(re),
    .dataOut(dout2), .full(full2), .empty(empty2));

  // Model update at the clock edge
  always @(posedge clk) begin
    for (int m = 0; m < 3; m++) begin
      if (rst) begin
        mWp[m] = 0; mRp[m] = 0; mCnt[m] = 0; mHold[m] = 0;
      end else begin
        bit ra, wa;
        ra = re && (mCnt[m] > 0);
        wa = we && (mCnt[m] < D) && ((m == 1) || !re);
        if (ra) begin
          if (m == 2) mHold[m] = mMem[m][mRp[m]];
          mRp[m] = (mRp[m] + 1) % D;
        end
        if (wa) begin
          mMem[m][mWp[m]] = int'(wd);
          mVal[m][mWp[m]] = 1'b1;
          mWp[m] = (mWp[m] + 1) % D;
        end
        mCnt[m] = mCnt[m] + int'(wa) - int'(ra);
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int doutOf(input int m);
    return (m == 0) ? int'(dout0) : (m == 1) ? int'(dout1) : int'(dout2);
  endfunction

  function automatic logic fullOf(input int m);
    return (m == 0) ? full0 : (m == 1) ? full1 : full2;
  endfunction

  function automatic logic emptyOf(input int m);
    return (m == 0) ? empty0 : (m == 1) ? empty1 : empty2;
  endfunction

  task automatic compareAll();
    for (int m = 0; m < 3; m++) begin
      int a;
      chk(emptyOf(m) === (mCnt[m] == 0), "R9 empty", int'(emptyOf(m)), int'(mCnt[m] == 0));
      chk(fullOf(m) === (mCnt[m] == D), "R9 full", int'(fullOf(m)), int'(mCnt[m] == D));
      if (m == 2) begin
        chk(dout2 === DW'(mHold[2]), "R8 held output", int'(dout2), mHold[2]);
      end else begin
        a = (m == 0 && !re) ? mWp[m] : mRp[m];
        if (mVal[m][a])
          chk(doutOf(m) == mMem[m][a], (m == 0) ? "R2 mux output" : "R7 read-port output",
              doutOf(m), mMem[m][a]);
      end
    end
  endtask

  // Drive one cycle of stimulus and compare before the next edge
  task automatic drive(input bit w, input bit r, input int d);
    @(negedge clk);
    we = w; re = r; wd = DW'(d);
    #2;
    compareAll();
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; we = 1'b0; re = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  bit done = 1'b0;

  initial begin
    #(20 * 150000);
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    for (int m = 0; m < 3; m++)
      for (int i = 0; i < D; i++) begin mVal[m][i] = 1'b0; mMem[m][i] = 0; end
    doReset();

    // R10: state after reset
    drive(0, 0, 0);
    chk(empty0 == 1'b1 && full0 == 1'b0, "R10 flags after reset", {full0, empty0}, 1);
    chk(dout2 == '0, "R10 hold cleared", int'(dout2), 0);

    // Fill with 0x10..0x13
    for (int i = 0; i < D; i++) drive(1, 0, 'h10 + i);
    // Write held while full
    drive(1, 0, 'hEE);
    chk(full0 == 1'b1, "R4 full after DEPTH writes", int'(full0), 1);
    chk(dout0 == 8'h10, "R5 wrapped output shows first entry", int'(dout0), 'h10);
    drive(1, 0, 'hEF);
    chk(dout0 == 8'h10, "R4 write pointer frozen while full", int'(dout0), 'h10);

    // Drain in order
    for (int i = 0; i < D; i++) begin
      drive(0, 1, 0);
      chk(dout0 == DW'('h10 + i), "R6 read order", int'(dout0), 'h10 + i);
      chk(dout1 == DW'('h10 + i), "R7 read port order", int'(dout1), 'h10 + i);
      if (i > 0) chk(dout2 == DW'('h10 + i - 1), "R8 hold loads read", int'(dout2), 'h10 + i - 1);
    end
    drive(0, 0, 0);
    chk(dout2 == 8'h13, "R8 hold keeps last read", int'(dout2), 'h13);
    chk(empty0 == 1'b1, "R4 no extra data after full writes", int'(empty0), 1);

    // Read while empty is ignored
    drive(0, 1, 0);
    drive(0, 1, 0);
    drive(1, 0, 'h20);
    drive(0, 1, 0);
    chk(dout0 == 8'h20, "R1 write then read returns data", int'(dout0), 'h20);
    chk(dout1 == 8'h20, "R6 empty reads did not move pointer", int'(dout1), 'h20);

    // Simultaneous read and write
    drive(1, 0, 'h30);
    drive(1, 1, 'h31);
    drive(0, 0, 0);
    chk(empty0 == 1'b1, "R3 shared mode rejects concurrent write", int'(empty0), 1);
    chk(empty1 == 1'b0, "R3 dual mode accepts concurrent write", int'(empty1), 0);

    // Mixed traffic against the model
    for (int c = 0; c < 600; c++) begin
      bit w, r;
      w = ($urandom % 100) < 55;
      r = ($urandom % 100) < 45;
      drive(w, r, int'($urandom % 256));
    end

    // Reset mid-run with data stored
    drive(1, 0, 'h44);
    doReset();
    drive(0, 0, 0);
    chk(empty1 == 1'b1 && full1 == 1'b0, "R10 flags after mid-run reset", {full1, empty1}, 1);
    chk(dout2 == '0, "R10 hold cleared mid-run", int'(dout2), 0);
    drive(1, 0, 'h55);
    drive(0, 1, 0);
    chk(dout0 == 8'h55, "R10 pointers restart at slot 0", int'(dout0), 'h55);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule